// File: doc/BRIEF.md
# Injected/Regular Conversion Sequencer

This block decides which conversion a filter channel performs next. Two classes of work compete for the channel. Injected groups have high priority and run a burst of back-to-back conversions. Regular conversions have lower priority and run either once or repeatedly while a continuous-mode enable is held.

The block takes these inputs:
- a start pulse for each class;
- the length of the injected group;
- the continuous-mode enable;
- a completion strobe from the filter datapath.

It returns these outputs:
- an in-progress flag for each class;
- a one-cycle start strobe with a class tag;
- a late marker that travels with a regular conversion started out of turn;
- an idle enable that lets the filter and integrator clocks be gated whenever no conversion is running.

An injected request pre-empts regular work. A regular conversion that is interrupted, or requested while an injected group runs, is deferred until the group ends. It then starts at once with the late marker set.

Control is one state machine with three states:
- `SEQ_IDLE`: nothing is running.
- `SEQ_INJ`: an injected group is running.
- `SEQ_REG`: a regular conversion is running.

Its transitions are:
- *inject-start*: from `SEQ_IDLE` or `SEQ_REG` to `SEQ_INJ`, on an injected start.
- *inject-next*: `SEQ_INJ` to `SEQ_INJ`, on completion while conversions remain in the group.
- *inject-end-to-regular*: `SEQ_INJ` to `SEQ_REG`, on the last completion of the group when regular work is waiting.
- *inject-end-to-idle*: `SEQ_INJ` to `SEQ_IDLE`, on the last completion when no regular work is waiting.
- *regular-start*: `SEQ_IDLE` to `SEQ_REG`.
- *regular-repeat*: `SEQ_REG` to `SEQ_REG`, on completion while continuous mode holds or a request is queued.
- *regular-end*: `SEQ_REG` to `SEQ_IDLE`.
- *pre-empt*: `SEQ_REG` to `SEQ_INJ`, on an injected start in a cycle without completion.

Top module: `conv_sequencer`

## Requirements
- R1: After synchronous reset `rst`, both in-progress flags, the start strobe and the late marker are 0, and `idle_en` is 1. Any queued regular request and any continuous session are cleared.
- R2: An injected start accepted from idle or from a regular conversion runs `inj_len`+1 conversions, each announced by `conv_go`=1 with `conv_inj`=1. `inj_busy` stays 1 until the completion of the last conversion.
- R3: A regular start from idle with `cont_en`=0 gives exactly one conversion (`conv_go`=1, `conv_inj`=0), holds `reg_busy` until its completion, and then returns to idle.
- R4: While `cont_en`=1, each regular completion issues a new regular conversion in the next cycle. Clearing `cont_en` lets the running conversion finish, and no further regular conversion follows.
- R5: An injected start during a regular conversion, in a cycle without `conv_done`, aborts that conversion at the next edge and starts the injected group. A single (non-continuous) aborted conversion is re-run after the group.
- R6: A regular start made during an injected group is held and issued right after the group's last completion, with `reg_late`=1.
- R7: A continuous session interrupted by an injected group restarts after the group only if `cont_en` is still 1 at the group's last completion.
- R8: Injected and regular starts in the same idle cycle run the injected group first and the regular conversion directly after it.
- R9: `reg_late` is 1 only during a regular conversion issued at the end of an injected group. Every other regular conversion, including the next one in a continuous session, carries 0.
- R10: `idle_en` is 1 exactly when neither `inj_busy` nor `reg_busy` is 1, and the two busy flags are never 1 together.
- R11: An injected start during an injected group is ignored: the group length and the flags are unchanged.
- R12: Every output responds at the first clock edge that samples the causing input; there is no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inj_start | input | 1 | Injected group start pulse |
| inj_len | input | LEN_W | Injected conversions in the group minus one |
| reg_start | input | 1 | Regular conversion start pulse |
| cont_en | input | 1 | Continuous regular mode enable |
| conv_done | input | 1 | Current conversion complete strobe from datapath |
| inj_busy | output | 1 | Injected group in progress |
| reg_busy | output | 1 | Regular conversion in progress |
| conv_go | output | 1 | One-cycle conversion start strobe |
| conv_inj | output | 1 | Class of the start strobe: 1 injected, 0 regular |
| reg_late | output | 1 | Running regular conversion was started late |
| idle_en | output | 1 | Filter and integrator may idle |

## Verification
Every result is due one clock after the edge that samples its cause. A start pulse raises the strobe and the busy flag one edge later. A completion strobe moves the flags and issues the next conversion one edge later, and a pre-empting injected start does the same. The late marker is set at that same edge. The bench drives inputs just after each falling edge and advances its reference model on the rising edge. It compares every output at the following falling edge, so each result is checked in the cycle it is due. Completion strobes come from a bench datapath model: it fires a fixed number of cycles after each observed start strobe and is reloaded when a start strobe pre-empts a conversion.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_INJ  = 2'd1,
        SEQ_REG  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/convseq_inj_count.sv
// Counts the injected conversions still to run in the current group.
module convseq_inj_count #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             step,
    output logic             last
);
    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)       left_q <= '0;
        else if (load) left_q <= len;
        else if (step) left_q <= left_q - 1'b1;
    end

    assign last = (left_q == '0);
endmodule

// File: rtl/convseq_reg_latch.sv
// Holds a queued regular request and the continuous-session marker.
module convseq_reg_latch (
    input  logic clk,
    input  logic rst,
    input  logic reg_start,
    input  logic cont_en,
    input  logic issue_reg,
    input  logic slot_free,
    input  logic preempt,
    output logic want_reg
);
    logic pend_q, loop_q;
    logic loop_live;

    assign loop_live = loop_q & cont_en;
    assign want_reg  = pend_q | reg_start | loop_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            loop_q <= 1'b0;
        end else begin
            // an aborted single conversion must be re-run
            if (issue_reg) pend_q <= 1'b0;
            else           pend_q <= pend_q | reg_start | (preempt & ~loop_live);

            if (issue_reg)      loop_q <= cont_en;
            else if (slot_free) loop_q <= loop_live;
        end
    end
endmodule

// File: rtl/convseq_fsm.sv
// Channel scheduling state machine.
module convseq_fsm
    import convseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inj_start,
    input  logic conv_done,
    input  logic want_reg,
    input  logic inj_last,
    output logic issue_inj,
    output logic inj_step,
    output logic issue_reg,
    output logic slot_free,
    output logic preempt,
    output logic inj_busy,
    output logic reg_busy,
    output logic conv_go,
    output logic conv_inj,
    output logic reg_late,
    output logic idle_en
);
    seq_state_t st_q, st_d;
    logic go_q, go_d, tag_q, tag_d, late_q, late_d;

    always_comb begin
        st_d      = st_q;
        issue_inj = 1'b0;
        inj_step  = 1'b0;
        slot_free = 1'b0;
        preempt   = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                slot_free = 1'b1;
                issue_inj = inj_start;
            end
            SEQ_INJ: begin
                inj_step  = conv_done & ~inj_last;
                slot_free = conv_done & inj_last;
            end
            SEQ_REG: begin
                slot_free = conv_done;
                issue_inj = inj_start;
                preempt   = inj_start & ~conv_done;
            end
            default: slot_free = 1'b1;
        endcase
        issue_reg = slot_free & ~issue_inj & want_reg;

        if (issue_inj | inj_step) st_d = SEQ_INJ;
        else if (issue_reg)       st_d = SEQ_REG;
        else if (slot_free)       st_d = SEQ_IDLE;

        go_d  = issue_inj | inj_step | issue_reg;
        tag_d = issue_inj | inj_step;
        if (issue_reg)                                     late_d = (st_q == SEQ_INJ);
        else if (st_q == SEQ_REG && !conv_done && !inj_start) late_d = late_q;
        else                                               late_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            go_q   <= 1'b0;
            tag_q  <= 1'b0;
            late_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            go_q   <= go_d;
            tag_q  <= tag_d;
            late_q <= late_d;
        end
    end

    always_comb begin
        inj_busy = (st_q == SEQ_INJ);
        reg_busy = (st_q == SEQ_REG);
        idle_en  = (st_q == SEQ_IDLE);
        conv_go  = go_q;
        conv_inj = tag_q;
        reg_late = late_q;
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inj_start,
    input  logic [LEN_W-1:0] inj_len,
    input  logic             reg_start,
    input  logic             cont_en,
    input  logic             conv_done,
    output logic             inj_busy,
    output logic             reg_busy,
    output logic             conv_go,
    output logic             conv_inj,
    output logic             reg_late,
    output logic             idle_en
);
    logic issue_inj, inj_step, issue_reg, slot_free, preempt;
    logic want_reg, inj_last;

    convseq_inj_count #(.LEN_W(LEN_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (issue_inj),
        .len  (inj_len),
        .step (inj_step),
        .last (inj_last)
    );

    convseq_reg_latch u_req (
        .clk       (clk),
        .rst       (rst),
        .reg_start (reg_start),
        .cont_en   (cont_en),
        .issue_reg (issue_reg),
        .slot_free (slot_free),
        .preempt   (preempt),
        .want_reg  (want_reg)
    );

    convseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .inj_start (inj_start),
        .conv_done (conv_done),
        .want_reg  (want_reg),
        .inj_last  (inj_last),
        .issue_inj (issue_inj),
        .inj_step  (inj_step),
        .issue_reg (issue_reg),
        .slot_free (slot_free),
        .preempt   (preempt),
        .inj_busy  (inj_busy),
        .reg_busy  (reg_busy),
        .conv_go   (conv_go),
        .conv_inj  (conv_inj),
        .reg_late  (reg_late),
        .idle_en   (idle_en)
    );
endmodule

// File: rtl/convseq_checks.sv
module convseq_checks (
    input logic clk,
    input logic rst,
    input logic inj_start,
    input logic conv_done,
    input logic inj_busy,
    input logic reg_busy,
    input logic conv_go,
    input logic conv_inj,
    input logic reg_late,
    input logic idle_en
);
    p_busy_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(inj_busy && reg_busy));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        idle_en == !(inj_busy || reg_busy));

    p_preempt_r5: assert property (@(posedge clk) disable iff (rst)
        reg_busy && inj_start && !conv_done |=> inj_busy && conv_go && conv_inj);

    p_late_in_reg_r9: assert property (@(posedge clk) disable iff (rst)
        reg_late |-> reg_busy);

    p_go_inj_r2: assert property (@(posedge clk) disable iff (rst)
        conv_go && conv_inj |-> inj_busy);

    p_go_reg_r3: assert property (@(posedge clk) disable iff (rst)
        conv_go && !conv_inj |-> reg_busy);

    p_inj_hold_r11: assert property (@(posedge clk) disable iff (rst)
        inj_busy && !conv_done |=> inj_busy && !conv_go);

    p_late_after_inj_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(inj_busy) && reg_busy |-> reg_late);
endmodule

bind conv_sequencer convseq_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .inj_start (inj_start),
    .conv_done (conv_done),
    .inj_busy  (inj_busy),
    .reg_busy  (reg_busy),
    .conv_go   (conv_go),
    .conv_inj  (conv_inj),
    .reg_late  (reg_late),
    .idle_en   (idle_en)
);

// File: tb/test_conv_sequencer.sv
`timescale 1ns/1ps
module test_conv_sequencer;
    localparam int LEN_W = 3;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inj_start = 1'b0, reg_start = 1'b0, cont_en = 1'b0, conv_done = 1'b0;
    logic [LEN_W-1:0] inj_len = '0;
    logic inj_busy, reg_busy, conv_go, conv_inj, reg_late, idle_en;

    int checks = 0;
    int errors = 0;
    string cur = "R1";

    // reference model: mode 0 idle, 1 injected, 2 regular
    int m_mode = 0, m_left = 0, dp = 0;
    bit m_pend = 0, m_loop = 0, m_late = 0, m_go = 0, m_tag = 0;

    always #10 clk = ~clk;

    conv_sequencer #(.LEN_W(LEN_W)) i_conv_sequencer (
        .clk(clk), .rst(rst), .inj_start(inj_start), .inj_len(inj_len),
        .reg_start(reg_start), .cont_en(cont_en), .conv_done(conv_done),
        .inj_busy(inj_busy), .reg_busy(reg_busy), .conv_go(conv_go),
        .conv_inj(conv_inj), .reg_late(reg_late), .idle_en(idle_en)
    );

    task automatic cmp(string tag, string name, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", tag, name, got, exp);
        end
    endtask

    task automatic model_step();
        bit busy_slot, want, take_inj, next_inj, take_reg, cut;
        int n_mode;
        busy_slot = 0;
        if (m_mode == 0) busy_slot = 1;
        if (m_mode == 1 && conv_done && m_left == 0) busy_slot = 1;
        if (m_mode == 2 && conv_done) busy_slot = 1;
        want     = m_pend || reg_start || (m_loop && cont_en);
        take_inj = inj_start && m_mode != 1;
        next_inj = m_mode == 1 && conv_done && m_left != 0;
        take_reg = busy_slot && !take_inj && want;
        cut      = m_mode == 2 && !conv_done && inj_start;
        n_mode = m_mode;
        if (take_inj || next_inj) n_mode = 1;
        else if (take_reg)        n_mode = 2;
        else if (busy_slot)       n_mode = 0;
        if (take_reg)                               m_late = (m_mode == 1);
        else if (!(m_mode == 2 && !conv_done && !inj_start)) m_late = 0;
        if (take_reg) m_pend = 0;
        else m_pend = m_pend || reg_start || (cut && !(m_loop && cont_en));
        if (take_reg)       m_loop = cont_en;
        else if (busy_slot) m_loop = m_loop && cont_en;
        if (take_inj)      m_left = int'(inj_len);
        else if (next_inj) m_left = m_left - 1;
        m_go  = take_inj || next_inj || take_reg;
        m_tag = take_inj || next_inj;
        m_mode = n_mode;
        if (m_go) dp = LAT;
        else if (dp > 0) dp--;
    endtask

    task automatic tick(bit i, bit r, bit c);
        inj_start = i; reg_start = r; cont_en = c;
        conv_done = (dp == 1);
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp(cur, "inj_busy", inj_busy, m_mode == 1);
        cmp(cur, "reg_busy", reg_busy, m_mode == 2);
        cmp(cur, "conv_go",  conv_go,  m_go);
        if (m_go) cmp(cur, "conv_inj", conv_inj, m_tag);
        cmp("R9",  "reg_late", reg_late, m_late);
        cmp("R10", "idle_en",  idle_en,  m_mode == 0);
    endtask

    task automatic idle(int n, bit c);
        for (int k = 0; k < n; k++) tick(0, 0, c);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cur = "R1";
        cmp("R1", "idle_en", idle_en, 1'b1);
        cmp("R1", "inj_busy", inj_busy, 1'b0);
        cmp("R1", "reg_busy", reg_busy, 1'b0);
        cmp("R1", "conv_go", conv_go, 1'b0);
        cmp("R1", "reg_late", reg_late, 1'b0);
        idle(2, 0);
        // R3 single regular
        cur = "R3"; tick(0, 1, 0); idle(6, 0);
        // R12 start strobe one edge after the request
        cur = "R12"; tick(0, 1, 0);
        cmp("R12", "conv_go immediate", conv_go, 1'b1);
        idle(6, 0);
        // R4 continuous then stop
        cur = "R4"; tick(0, 1, 1); idle(10, 1); idle(8, 0);
        // R2 injected group of three
        cur = "R2"; inj_len = 3'd2; tick(1, 0, 0); idle(12, 0);
        // R7 continuous pre-empted, cont kept: restarts late
        cur = "R7"; inj_len = 3'd1; tick(0, 1, 1); idle(1, 1);
        tick(1, 0, 1); idle(14, 1); idle(6, 0);
        // R7 continuous pre-empted, cont cleared during group: no restart
        tick(0, 1, 1); idle(4, 1); tick(1, 0, 1); idle(2, 1); idle(12, 0);
        // R8 simultaneous starts
        cur = "R8"; inj_len = 3'd0; tick(1, 1, 0); idle(10, 0);
        // R6 regular request during group
        cur = "R6"; inj_len = 3'd2; tick(1, 0, 0); idle(2, 0);
        tick(0, 1, 0); idle(14, 0);
        // R11 injected start during a group ignored
        cur = "R11"; inj_len = 3'd1; tick(1, 0, 0); idle(1, 0);
        inj_len = 3'd5; tick(1, 0, 0); idle(12, 0);
        // R5 single regular pre-empted, re-run late
        cur = "R5"; inj_len = 3'd0; tick(0, 1, 0); idle(1, 0);
        tick(1, 0, 0);
        cmp("R5", "pre-empt flag", inj_busy, 1'b1);
        idle(12, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule